// File: doc/BRIEF.md
# Shared-Output Yield Arbiter with Bypass Queues

This block decides, one packet at a time, who may use a router output port. Two kinds of traffic share the port. The first is the router's own local (primary) stream. The second comes from a set of bypass lanes that carry packets past the router without a full routing stage. Each bypass lane writes into a small private FIFO inside the block. The primary stream normally wins the port. A bypass lane gets the port when the primary has nothing to offer. When several bypass lanes are waiting, they are served in rotating order.

Without a guard, a busy primary stream could keep a bypass lane waiting forever. To prevent this, each bypass lane counts the cycles in which its queue holds data but the port is not assigned to it. When a count saturates at the threshold, the block sends a one-cycle control packet naming that lane. The block also acts on that control packet itself: at the next packet boundary the primary yields the port for exactly one packet of the named lane.

Every data interface uses valid/ready. A flit moves only in a cycle where valid and ready are both high. Once a source has offered a flit on the output, the choice of source is held until that flit is taken, and the source must keep its data stable. A packet, from its first flit through the flit marked last, is never interrupted. The output is combinational from the chosen source, so a flit can pass from input to output in the same cycle.

Top module: `byp_yield_arb`

## Requirements
- R1: At a packet boundary, with no yield pending and `prim_valid` high, the output is given to the primary, and `out_src` reads 0.
- R2: A bypass lane i is granted only when its FIFO is non-empty, and only when the primary is not offering or a yield for lane i is pending. It is then shown as `out_src` = i+1, and `out_valid` equals that FIFO's non-empty flag.
- R3: Each bypass lane buffers up to 4 flits in arrival order. `np_ready[i]` is low exactly when 4 flits are held, and flits leave in the order they came in.
- R4: After a flit with `out_last` low is transferred, the next transfer comes from the same source. The port is re-arbitrated only after a transfer with `out_last` high.
- R5: With no yield pending and the primary not offering, the bypass lanes are served in rotating order. The search starts at the lane after the last bypass lane granted a packet head. After reset the search starts at lane 0.
- R6: Each lane's wait count goes up by one in every cycle where its FIFO is non-empty and `out_src` does not name it. The count saturates at 16 and clears when one of its flits is transferred. One cycle after a count first sits at 16 with no yield pending, `ctrl_valid` pulses for one cycle, and `ctrl_dst` carries the lowest saturated lane index.
- R7: After that control pulse, the next packet boundary grants the named lane, even if the primary is offering. The yield then clears when that lane's head flit is transferred.
- R8: After reset, all FIFOs are empty (`np_ready` all ones), `out_valid` and `ctrl_valid` are low, and all wait counts are zero.
- R9: With `out_ready` held high and sources sending whole packets back to back, no non-empty bypass lane goes unserved for more than 64 consecutive cycles.
- R10: If `out_valid` is high and `out_ready` is low, the chosen source, `out_src` and `out_data` stay unchanged in the next cycle. `prim_ready` is high only when `out_ready` is high and the primary is the chosen source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prim_valid | input | 1 | Primary flit offered |
| prim_ready | output | 1 | Primary flit accepted this cycle |
| prim_data | input | DW | Primary flit payload |
| prim_last | input | 1 | Primary flit ends its packet |
| np_valid | input | N_BYP | Bypass lane flit offered, one bit per lane |
| np_ready | output | N_BYP | Bypass lane FIFO has room |
| np_data | input | N_BYP*DW | Bypass lane payloads, lane i at bits [i*DW +: DW] |
| np_last | input | N_BYP | Bypass lane flit ends its packet |
| out_valid | output | 1 | Output flit offered |
| out_ready | input | 1 | Downstream accepts the output flit |
| out_data | output | DW | Output flit payload |
| out_last | output | 1 | Output flit ends its packet |
| out_src | output | SW | Current source: 0 is the primary, i+1 is bypass lane i |
| ctrl_valid | output | 1 | Starvation control packet, one-cycle pulse |
| ctrl_dst | output | IW | Bypass lane named by the control packet |

## Verification
The outputs `out_valid`, `out_src`, `out_data`, `out_last`, `prim_ready` and `np_ready` are combinational from the current inputs and state. They are due in the same cycle that the inputs are driven, so the bench drives at the falling edge and compares one time unit later. FIFO contents, wait counts, the packet lock and the rotation pointer change at the next rising edge. A control pulse shows up one full cycle after the count that causes it saturates. The bench's reference model updates its queues and counters at that rising edge and checks the pulse in the following cycle. The model is compared on every clock against all outputs. A separate per-lane counter in the bench, driven from the observed `out_src`, checks the waiting bound.

// File: rtl/yarb_pkg.sv
package yarb_pkg;
  // Source code on out_src that names the local (primary) stream.
  localparam int unsigned SRC_PRIMARY = 0;

  // Bits needed to hold a count from 0 up to and including lim.
  function automatic int unsigned cnt_bits(input int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction
endpackage

// File: rtl/yarb_fifo.sv
module yarb_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          push_last,
  input  logic          pop,
  output logic [DW-1:0] head_data,
  output logic          head_last,
  output logic          full,
  output logic          nonempty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = yarb_pkg::cnt_bits(DEPTH);

  logic [DW-1:0] mem_d [DEPTH];
  logic          mem_l [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] fill;
  logic          do_push, do_pop;

  assign full      = (fill == CW'(DEPTH));
  assign nonempty  = (fill != '0);
  assign do_push   = push && !full;
  assign do_pop    = pop && nonempty;
  assign head_data = mem_d[rd_ptr];
  assign head_last = mem_l[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) begin
      mem_d[wr_ptr] <= push_data;
      mem_l[wr_ptr] <= push_last;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/yarb_wait.sv
module yarb_wait #(
  parameter int THRESH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic waiting,
  input  logic served,
  output logic sat
);
  localparam int WW = yarb_pkg::cnt_bits(THRESH);

  logic [WW-1:0] cnt;

  assign sat = (cnt == WW'(THRESH));

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (served)           cnt <= '0;
    else if (waiting && !sat)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/yarb_pick.sv
module yarb_pick #(
  parameter int N_BYP = 3,
  parameter int SW    = 2,
  parameter int IW    = 2
) (
  input  logic [N_BYP-1:0] ne,
  input  logic             prim_valid,
  input  logic             hold,
  input  logic [SW-1:0]    hold_src,
  input  logic             pend,
  input  logic [IW-1:0]    ysrc,
  input  logic [IW-1:0]    rr_ptr,
  output logic [SW-1:0]    sel
);
  logic [SW-1:0] rr_sel;
  logic [IW-1:0] idx;
  logic          found;

  // Rotating search that starts at the lane after rr_ptr.
  always_comb begin
    rr_sel = SW'(yarb_pkg::SRC_PRIMARY);
    found  = 1'b0;
    idx    = rr_ptr;
    for (int k = 0; k < N_BYP; k++) begin
      idx = (idx == IW'(N_BYP - 1)) ? '0 : idx + 1'b1;
      if (!found && ne[idx]) begin
        found  = 1'b1;
        rr_sel = SW'(idx) + SW'(1);
      end
    end
  end

  always_comb begin
    if (hold)                  sel = hold_src;
    else if (pend && ne[ysrc]) sel = SW'(ysrc) + SW'(1);
    else if (prim_valid)       sel = SW'(yarb_pkg::SRC_PRIMARY);
    else                       sel = rr_sel;
  end
endmodule

// File: rtl/byp_yield_arb.sv
module byp_yield_arb #(
  parameter int N_BYP  = 3,
  parameter int DW     = 16,
  parameter int DEPTH  = 4,
  parameter int THRESH = 16,
  parameter int SW     = $clog2(N_BYP + 1),
  parameter int IW     = (N_BYP > 1) ? $clog2(N_BYP) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                prim_valid,
  output logic                prim_ready,
  input  logic [DW-1:0]       prim_data,
  input  logic                prim_last,
  input  logic [N_BYP-1:0]    np_valid,
  output logic [N_BYP-1:0]    np_ready,
  input  logic [N_BYP*DW-1:0] np_data,
  input  logic [N_BYP-1:0]    np_last,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DW-1:0]       out_data,
  output logic                out_last,
  output logic [SW-1:0]       out_src,
  output logic                ctrl_valid,
  output logic [IW-1:0]       ctrl_dst
);
  logic [N_BYP-1:0] ne, full, sat, pop;
  logic [DW-1:0]    hd [N_BYP];
  logic [N_BYP-1:0] hl;
  logic [SW-1:0]    sel, lock_src;
  logic             in_pkt_q, held_q, pend_q;
  logic [IW-1:0]    ysrc_q, rr_q, trig_idx;
  logic             trig, xfer, head_xfer;

  genvar g;
  generate
    for (g = 0; g < N_BYP; g++) begin : g_lane
      yarb_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(np_valid[g]), .push_data(np_data[g*DW +: DW]), .push_last(np_last[g]),
        .pop(pop[g]), .head_data(hd[g]), .head_last(hl[g]),
        .full(full[g]), .nonempty(ne[g])
      );
      yarb_wait #(.THRESH(THRESH)) u_wait (
        .clk(clk), .rst_n(rst_n),
        .waiting(ne[g] && (sel != SW'(g + 1))),
        .served(xfer && (sel == SW'(g + 1))),
        .sat(sat[g])
      );
      assign pop[g] = out_ready && (sel == SW'(g + 1));
    end
  endgenerate

  yarb_pick #(.N_BYP(N_BYP), .SW(SW), .IW(IW)) u_pick (
    .ne(ne), .prim_valid(prim_valid),
    .hold(in_pkt_q || held_q), .hold_src(lock_src),
    .pend(pend_q), .ysrc(ysrc_q), .rr_ptr(rr_q), .sel(sel)
  );

  // Output multiplexer: primary by default, a lane head when selected.
  always_comb begin
    out_valid = prim_valid;
    out_data  = prim_data;
    out_last  = prim_last;
    for (int i = 0; i < N_BYP; i++) begin
      if (sel == SW'(i + 1)) begin
        out_valid = ne[i];
        out_data  = hd[i];
        out_last  = hl[i];
      end
    end
  end

  assign out_src    = sel;
  assign np_ready   = ~full;
  assign prim_ready = out_ready && (sel == SW'(yarb_pkg::SRC_PRIMARY));
  assign xfer       = out_valid && out_ready;
  assign head_xfer  = xfer && !in_pkt_q;

  // Lowest-indexed saturated lane raises the next control packet.
  always_comb begin
    trig     = 1'b0;
    trig_idx = '0;
    for (int i = N_BYP - 1; i >= 0; i--) begin
      if (sat[i]) begin
        trig     = 1'b1;
        trig_idx = IW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt_q   <= 1'b0;
      held_q     <= 1'b0;
      lock_src   <= '0;
      pend_q     <= 1'b0;
      ysrc_q     <= '0;
      rr_q       <= IW'(N_BYP - 1);
      ctrl_valid <= 1'b0;
      ctrl_dst   <= '0;
    end else begin
      lock_src <= sel;
      if (xfer) begin
        in_pkt_q <= !out_last;
        held_q   <= 1'b0;
      end else if (out_valid) begin
        held_q   <= 1'b1;
      end
      if (head_xfer && (sel != SW'(yarb_pkg::SRC_PRIMARY)))
        rr_q <= IW'(sel - SW'(1));
      if (pend_q && head_xfer && (sel == SW'(ysrc_q) + SW'(1))) begin
        pend_q <= 1'b0;
      end else if (!pend_q && trig) begin
        pend_q <= 1'b1;
        ysrc_q <= trig_idx;
      end
      ctrl_valid <= !pend_q && trig;
      ctrl_dst   <= trig_idx;
    end
  end
endmodule

// File: rtl/byp_yield_arb_chk.sv
module byp_yield_arb_chk #(
  parameter int DW = 16,
  parameter int SW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          prim_valid,
  input logic          out_valid,
  input logic          out_ready,
  input logic          out_last,
  input logic [DW-1:0] out_data,
  input logic [SW-1:0] out_src,
  input logic          ctrl_valid,
  input logic          in_pkt,
  input logic          held,
  input logic          pend
);
  // R1: primary wins a free boundary when no yield is pending
  p_prim_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_pkt && !held && !pend && prim_valid) |-> (out_src == '0));

  // R2: a bypass grant at a boundary needs an idle primary or a pending yield
  p_np_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_src != '0 && !in_pkt && !held) |-> (!prim_valid || pend));

  // R4: a packet is never split between sources
  p_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> (out_src == $past(out_src)));

  // R6: a control packet lasts one cycle
  p_ctrl_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_valid |=> !ctrl_valid);

  // R10: a stalled offer keeps its source and payload
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_src) && $stable(out_data)));
endmodule

bind byp_yield_arb byp_yield_arb_chk #(.DW(DW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .prim_valid(prim_valid),
  .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
  .out_data(out_data), .out_src(out_src), .ctrl_valid(ctrl_valid),
  .in_pkt(in_pkt_q), .held(held_q), .pend(pend_q)
);

// File: tb/byp_yield_arb_test.sv
`timescale 1ns/1ps
module byp_yield_arb_test;
  localparam int N = 3, DW = 16, DEPTH = 4, TH = 16, MAXLEN = 4, BOUND = 64;
  localparam int SW = 2, IW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic prim_valid = 0, prim_last = 0, out_ready = 0;
  logic [DW-1:0] prim_data = '0;
  logic [N-1:0] np_valid = '0, np_last = '0;
  logic [N*DW-1:0] np_data = '0;
  logic prim_ready, out_valid, out_last, ctrl_valid;
  logic [N-1:0] np_ready;
  logic [DW-1:0] out_data;
  logic [SW-1:0] out_src;
  logic [IW-1:0] ctrl_dst;

  always #4 clk = ~clk;

  byp_yield_arb #(.N_BYP(N), .DW(DW), .DEPTH(DEPTH), .THRESH(TH)) uut (
    .clk(clk), .rst_n(rst_n), .prim_valid(prim_valid), .prim_ready(prim_ready),
    .prim_data(prim_data), .prim_last(prim_last), .np_valid(np_valid),
    .np_ready(np_ready), .np_data(np_data), .np_last(np_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .out_src(out_src), .ctrl_valid(ctrl_valid), .ctrl_dst(ctrl_dst));

  int nchk = 0, nerr = 0;
  logic [DW-1:0] qd [N][$];
  bit            ql [N][$];
  int  m_cnt [N];
  bit  m_inpkt, m_held, m_pend, m_ctrl;
  int  m_lock, m_ysrc, m_rr, m_cdst;
  bit  s_on [N+1];
  logic [DW-1:0] s_d [N+1];
  bit  s_l [N+1];
  int  s_rem [N+1], s_seq [N+1], rate [N+1];
  int  rdy = 100, bw [N];
  bit  bound_on = 0, saw_full = 0;
  int  ctrl_seen = 0, yield_grants = 0;

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic gen(int s);
    if (s_rem[s] == 0) begin
      if (int'($urandom % 100) >= rate[s]) begin s_on[s] = 0; return; end
      s_rem[s] = 1 + int'($urandom % MAXLEN);
    end
    s_seq[s]++;
    s_d[s] = DW'(s * 4096 + (s_seq[s] % 4096));
    s_rem[s]--;
    s_l[s] = (s_rem[s] == 0);
    s_on[s] = 1;
  endtask

  function automatic int model_sel();
    if (m_inpkt || m_held) return m_lock;
    if (m_pend && qd[m_ysrc].size() > 0) return m_ysrc + 1;
    if (prim_valid) return 0;
    for (int k = 1; k <= N; k++) begin
      int idx = (m_rr + k) % N;
      if (qd[idx].size() > 0) return idx + 1;
    end
    return 0;
  endfunction

  task automatic cycle();
    int sel, trig, osize [N];
    bit ev, elast, xfer, head, acc [N+1];
    @(negedge clk);
    prim_valid = s_on[0]; prim_data = s_d[0]; prim_last = s_l[0];
    for (int i = 0; i < N; i++) begin
      np_valid[i] = s_on[i+1]; np_data[i*DW +: DW] = s_d[i+1]; np_last[i] = s_l[i+1];
    end
    out_ready = (int'($urandom % 100) < rdy);
    #1;
    sel = model_sel();
    ev = (sel == 0) ? prim_valid : (qd[sel-1].size() > 0);
    elast = (sel == 0) ? prim_last : (ev ? ql[sel-1][0] : 0);
    chk("R1/R2 out_valid", out_valid, ev);
    if (ev) begin
      chk("R1/R2/R5/R7 out_src", out_src, sel);
      chk("R3/R4 out_data", out_data, (sel == 0) ? prim_data : qd[sel-1][0]);
      chk("R4 out_last", out_last, elast);
    end
    chk("R10 prim_ready", prim_ready, out_ready && sel == 0);
    chk("R6 ctrl_valid", ctrl_valid, m_ctrl);
    if (m_ctrl) begin
      chk("R6 ctrl_dst", ctrl_dst, m_cdst);
      ctrl_seen++;
    end
    for (int i = 0; i < N; i++) begin
      osize[i] = qd[i].size();
      chk("R3 np_ready", np_ready[i], osize[i] < DEPTH);
      if (osize[i] == DEPTH) saw_full = 1;
      if (osize[i] > 0 && !(out_valid && int'(out_src) == i + 1)) bw[i]++;
      else bw[i] = 0;
      if (bound_on && bw[i] > BOUND) begin
        chk("R9 lane wait bound", bw[i], BOUND);
        bw[i] = 0;
      end
    end
    xfer = ev && out_ready;
    head = xfer && !m_inpkt;
    trig = -1;
    for (int i = N - 1; i >= 0; i--) if (m_cnt[i] == TH) trig = i;
    acc[0] = prim_valid && out_ready && sel == 0;
    for (int i = 0; i < N; i++) acc[i+1] = np_valid[i] && osize[i] < DEPTH;
    @(posedge clk);
    if (xfer && sel != 0) begin void'(qd[sel-1].pop_front()); void'(ql[sel-1].pop_front()); end
    for (int i = 0; i < N; i++) begin
      if (acc[i+1]) begin qd[i].push_back(s_d[i+1]); ql[i].push_back(s_l[i+1]); end
      if (xfer && sel == i + 1) m_cnt[i] = 0;
      else if (osize[i] > 0 && sel != i + 1 && m_cnt[i] < TH) m_cnt[i]++;
    end
    if (head && sel != 0) m_rr = sel - 1;
    m_ctrl = !m_pend && trig >= 0;
    m_cdst = trig;
    if (m_pend && head && sel == m_ysrc + 1) begin
      m_pend = 0;
      if (prim_valid) yield_grants++;
    end else if (!m_pend && trig >= 0) begin
      m_pend = 1; m_ysrc = trig;
    end
    m_lock = sel;
    if (xfer) begin m_inpkt = !elast; m_held = 0; end
    else if (ev) m_held = 1;
    for (int s = 0; s <= N; s++) if (!s_on[s] || acc[s]) gen(s);
  endtask

  task automatic phase(int n, int pr, int nr, int r, bit b);
    rate[0] = pr;
    for (int i = 1; i <= N; i++) rate[i] = nr;
    rdy = r; bound_on = b;
    for (int c = 0; c < n; c++) cycle();
  endtask

  initial begin
    #(8 * 60000);
    nerr++;
    $display("FAIL R9 watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    for (int s = 0; s <= N; s++) begin s_on[s] = 0; s_rem[s] = 0; s_seq[s] = 0; s_l[s] = 0; s_d[s] = '0; end
    for (int i = 0; i < N; i++) begin m_cnt[i] = 0; bw[i] = 0; end
    m_inpkt = 0; m_held = 0; m_pend = 0; m_ctrl = 0; m_lock = 0; m_ysrc = 0; m_cdst = 0; m_rr = N - 1;
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R8: state right after reset
    chk("R8 out_valid after reset", out_valid, 0);
    chk("R8 np_ready after reset", np_ready, (1 << N) - 1);
    chk("R8 ctrl_valid after reset", ctrl_valid, 0);
    phase(600, 100, 60, 100, 1);  // R6/R7: busy primary forces yields
    phase(600, 0, 80, 100, 1);    // R5: rotation among lanes
    phase(800, 50, 50, 60, 0);    // R10: back-pressure mix
    phase(20, 0, 100, 0, 0);      // R3: fill queues with the output stalled
    phase(300, 30, 30, 100, 1);
    chk("R6 control packets seen", ctrl_seen > 0, 1);
    chk("R7 yields against an offering primary", yield_grants > 0, 1);
    chk("R3 a queue reached capacity", saw_full, 1);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule